// File: doc/BRIEF.md
# Reset Qualification and Emulation-Mode Entry Controller

This block sits between the reset, address-strobe, program-strobe and external-access pins and the rest of a small controller core. It filters the raw reset pin so that the core is only reset after the pin has stayed high for two machine cycles of oscillator clocks. Any shorter pulse is discarded.

While the qualified reset is active, the block watches the address strobe and program strobe levels. The address strobe may be held low with the program strobe high during reset, and kept low at the moment reset is released. In that case the device enters an in-circuit emulation mode instead of starting to run. In that mode the multiplexed data port is released to float, and the other ports and both strobes fall back to weak pull-ups. The mode persists until a later qualified reset is released with the address strobe high.

When a code-protection lock bit is programmed, the external-access strap is captured during reset and held. Otherwise it is passed straight through.

Top module: `rstemu_ctrl`

## Requirements
- R1: After the synchronous bench reset `rst_n`, `core_rst`, `emu_mode`, `p0_float` and `weak_pull` are all 0.
- R2: `core_rst` rises in the cycle after the 24th consecutive clock edge at which `rst_pin` is sampled high. After only 23 such edges it is still 0.
- R3: A single edge that samples `rst_pin` low restarts the count, so a further 24 consecutive high samples are needed.
- R4: `core_rst` falls at the first edge that samples `rst_pin` low. This edge is the release edge.
- R5: `emu_mode` becomes 1 at a release edge when `ale_pin`=0 and `psen_pin`=1 were both sampled at the previous edge while `core_rst` was 1, and `ale_pin` is 0 at the release edge.
- R6: A release edge with `ale_pin`=1 clears `emu_mode` to 0. This is the normal exit.
- R7: A release with `ale_pin`=0 does not set `emu_mode` if `psen_pin` was 0 at the preceding in-reset edge.
- R8: `emu_mode` changes only at release edges. It holds its value while reset is asserted and through `rst_pin` pulses shorter than 24 clocks.
- R9: `p0_float` and `weak_pull` are 1 exactly when `emu_mode` is 1.
- R10: With `lock_any`=1, `ea_eff` equals `ea_pin` as sampled at the last edge during asserted reset, including the release edge. Later changes of `ea_pin` do not affect it.
- R11: With `lock_any`=0, `ea_eff` follows `ea_pin` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low register reset |
| rst_pin | input | 1 | Raw reset pin level, active high |
| ale_pin | input | 1 | Address strobe pin level |
| psen_pin | input | 1 | Program strobe pin level |
| ea_pin | input | 1 | External-access strap pin level |
| lock_any | input | 1 | 1 when any program lock bit is programmed |
| core_rst | output | 1 | Qualified internal reset, active high |
| emu_mode | output | 1 | In-circuit emulation mode flag |
| p0_float | output | 1 | Release the data port to high impedance |
| weak_pull | output | 1 | Put other ports and strobes on weak pull-ups |
| ea_eff | output | 1 | External-access level seen by the core |

## Verification
The qualifier is driven with exactly 23 and then 24 high samples, and with a 23-high run broken by one low sample. Together these pin down the counter limit and the restart.

Entry is tried with three strobe patterns: the correct one, one with the program strobe low, and one with the address strobe high at release. These separate true entry, a missing precondition and the normal exit. Short reset pulses during emulation show that the flag is not disturbed.

The strap is toggled after release with and without the lock flag. This distinguishes a held sample from a pass-through.

// File: rtl/rstemu_pkg.sv
// Shared types for the reset / emulation-mode controller.
// Assumes a single oscillator clock domain for all users.
package rstemu_pkg;
    // Pad overrides applied while emulation mode is active
    typedef struct packed {
        logic p0_float;
        logic weak_pull;
    } pad_ctl_t;
endpackage

// File: rtl/rst_qualifier.sv
// Qualifies the raw reset pin: the internal reset asserts only after
// HOLD_CLKS consecutive high samples and drops on the first low sample.
// Assumes rst_pin is already synchronised to clk.
module rst_qualifier #(
    parameter int CLKS_PER_MC = 12,
    parameter int MC_COUNT    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    output logic core_rst,
    output logic release_evt
);
    localparam int HOLD_CLKS = CLKS_PER_MC * MC_COUNT;
    localparam int CNT_W     = $clog2(HOLD_CLKS + 1);
    localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CLKS);

    logic [CNT_W-1:0] high_cnt;

    // Count consecutive high samples, saturating at the hold limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
        end else if (!rst_pin) begin
            high_cnt <= '0;
        end else if (high_cnt != HOLD_VAL) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    // Internal reset is the saturated state of the counter
    always_comb begin
        core_rst    = (high_cnt == HOLD_VAL);
        release_evt = core_rst && !rst_pin;
    end
endmodule

// File: rtl/emu_entry_detect.sv
// Detects the strobe pattern that selects emulation mode at reset release.
// Arms when ALE low / PSEN high is seen during asserted reset; decides the
// mode only at the release edge. Assumes pins synchronised to clk.
module emu_entry_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic core_rst,
    input  logic release_evt,
    input  logic ale_pin,
    input  logic psen_pin,
    output logic emu_mode
);
    logic armed;

    // Remember whether the entry precondition held at the last in-reset edge
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst) begin
            armed <= 1'b0;
        end else begin
            armed <= !ale_pin && psen_pin;
        end
    end

    // Set or clear the mode flag only when reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emu_mode <= 1'b0;
        end else if (release_evt) begin
            emu_mode <= armed && !ale_pin;
        end
    end
endmodule

// File: rtl/ea_strap_latch.sv
// External-access strap handling: with protection active the level is
// captured during reset and held; otherwise it passes straight through.
module ea_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic core_rst,
    input  logic ea_pin,
    input  logic lock_any,
    output logic ea_eff
);
    logic ea_hold;

    // Track the strap while reset is asserted, freeze it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_hold <= 1'b0;
        end else if (core_rst) begin
            ea_hold <= ea_pin;
        end
    end

    // Select held or live strap level
    always_comb begin
        ea_eff = lock_any ? ea_hold : ea_pin;
    end
endmodule

// File: rtl/rstemu_ctrl.sv
// Top of the reset and emulation-mode entry controller. Connects the
// reset qualifier, the entry detector and the strap latch, and derives
// the pad overrides from the mode flag.
module rstemu_ctrl #(
    parameter int CLKS_PER_MC = 12,
    parameter int MC_COUNT    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic ale_pin,
    input  logic psen_pin,
    input  logic ea_pin,
    input  logic lock_any,
    output logic core_rst,
    output logic emu_mode,
    output logic p0_float,
    output logic weak_pull,
    output logic ea_eff
);
    import rstemu_pkg::*;

    logic     release_evt;
    pad_ctl_t pad_ctl;

    rst_qualifier #(
        .CLKS_PER_MC(CLKS_PER_MC),
        .MC_COUNT   (MC_COUNT)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_pin    (rst_pin),
        .core_rst   (core_rst),
        .release_evt(release_evt)
    );

    emu_entry_detect u_emu (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst   (core_rst),
        .release_evt(release_evt),
        .ale_pin    (ale_pin),
        .psen_pin   (psen_pin),
        .emu_mode   (emu_mode)
    );

    ea_strap_latch u_ea (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_rst(core_rst),
        .ea_pin  (ea_pin),
        .lock_any(lock_any),
        .ea_eff  (ea_eff)
    );

    // Pad overrides follow the emulation flag
    always_comb begin
        pad_ctl.p0_float  = emu_mode;
        pad_ctl.weak_pull = emu_mode;
    end

    assign p0_float  = pad_ctl.p0_float;
    assign weak_pull = pad_ctl.weak_pull;
endmodule

// File: rtl/rstemu_ctrl_chk.sv
// Property checker for rstemu_ctrl, attached by bind. Keeps its own
// consecutive-high counter to check the qualification window.
module rstemu_ctrl_chk #(
    parameter int CLKS_PER_MC = 12,
    parameter int MC_COUNT    = 2
) (
    input logic clk,
    input logic rst_n,
    input logic rst_pin,
    input logic ale_pin,
    input logic lock_any,
    input logic core_rst,
    input logic emu_mode,
    input logic p0_float,
    input logic weak_pull,
    input logic ea_eff
);
    localparam int HOLD_CLKS = CLKS_PER_MC * MC_COUNT;
    int hi_run;

    // Independent run-length of high reset-pin samples
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_pin) hi_run <= 0;
        else if (hi_run < HOLD_CLKS) hi_run <= hi_run + 1;
    end

    // R2
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> (hi_run >= HOLD_CLKS));

    // R4
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin |=> !core_rst);

    // R6
    normal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && !rst_pin && ale_pin) |=> !emu_mode);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rst && !rst_pin) |=> $stable(emu_mode));

    // R10
    ea_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_any && !core_rst) |=> (!lock_any || $stable(ea_eff)));

    // R9
    always_comb begin
        if (rst_n) begin
            pad_follow_chk: assert (p0_float == emu_mode && weak_pull == emu_mode);
        end
    end
endmodule

bind rstemu_ctrl rstemu_ctrl_chk #(
    .CLKS_PER_MC(CLKS_PER_MC),
    .MC_COUNT   (MC_COUNT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_pin  (rst_pin),
    .ale_pin  (ale_pin),
    .lock_any (lock_any),
    .core_rst (core_rst),
    .emu_mode (emu_mode),
    .p0_float (p0_float),
    .weak_pull(weak_pull),
    .ea_eff   (ea_eff)
);

// File: tb/rstemu_ctrl_test.sv
// Scoreboard bench: the driver pushes expected output sets into a queue
// right after a rising edge; the monitor pops and compares at the next
// falling edge.
module rstemu_ctrl_test;
    typedef struct {
        string req;
        logic  core;
        logic  emu;
        logic  ea;
        bit    chk_ea;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b0;
    logic ale_pin = 1'b1;
    logic psen_pin = 1'b1;
    logic ea_pin = 1'b1;
    logic lock_any = 1'b0;
    logic core_rst, emu_mode, p0_float, weak_pull, ea_eff;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    rstemu_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_pin  (rst_pin),
        .ale_pin  (ale_pin),
        .psen_pin (psen_pin),
        .ea_pin   (ea_pin),
        .lock_any (lock_any),
        .core_rst (core_rst),
        .emu_mode (emu_mode),
        .p0_float (p0_float),
        .weak_pull(weak_pull),
        .ea_eff   (ea_eff)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic core, input logic emu,
                              input bit chk_ea, input logic ea);
        exp_t e;
        e.req = req; e.core = core; e.emu = emu; e.ea = ea; e.chk_ea = chk_ea;
        sb_q.push_back(e);
    endtask

    // Monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (core_rst !== e.core || emu_mode !== e.emu ||
                p0_float !== e.emu || weak_pull !== e.emu ||
                (e.chk_ea && ea_eff !== e.ea)) begin
                n_fail++;
                $display("FAIL %s: core=%b emu=%b p0f=%b weak=%b ea=%b, expected core=%b emu=%b pads=%b ea=%b",
                         e.req, core_rst, emu_mode, p0_float, weak_pull, ea_eff,
                         e.core, e.emu, e.emu, e.ea);
            end
        end
    end

    // Apply a full qualified reset, arriving just after core_rst rises
    task automatic enter_reset();
        rst_pin = 1'b1;
        cyc(24);
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        expect_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1);

        // R2: 23 highs not enough, 24th asserts
        rst_pin = 1'b1;
        cyc(23);
        expect_out("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1);
        expect_out("R2", 1'b1, 1'b0, 1'b0, 1'b0);
        // R4: first low sample drops reset, ALE high so no emulation
        rst_pin = 1'b0;
        cyc(1);
        expect_out("R4", 1'b0, 1'b0, 1'b0, 1'b0);

        // R3: a single low sample restarts the count
        rst_pin = 1'b1;
        cyc(23);
        rst_pin = 1'b0;
        cyc(1);
        rst_pin = 1'b1;
        cyc(23);
        expect_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1);
        expect_out("R3", 1'b1, 1'b0, 1'b0, 1'b0);

        // R5: ALE low, PSEN high in reset, ALE low at release
        ale_pin = 1'b0; psen_pin = 1'b1;
        cyc(3);
        expect_out("R8", 1'b1, 1'b0, 1'b0, 1'b0);
        rst_pin = 1'b0;
        cyc(1);
        expect_out("R5", 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R9", 1'b0, 1'b1, 1'b0, 1'b0);
        ale_pin = 1'b1;
        cyc(5);
        expect_out("R8", 1'b0, 1'b1, 1'b0, 1'b0);

        // R8: a short pulse with ALE high at its end leaves the mode set
        rst_pin = 1'b1;
        cyc(10);
        rst_pin = 1'b0;
        cyc(2);
        expect_out("R8", 1'b0, 1'b1, 1'b0, 1'b0);

        // R8: mode held during a full reset; R6: normal release clears it
        enter_reset();
        cyc(2);
        expect_out("R8", 1'b1, 1'b1, 1'b0, 1'b0);
        rst_pin = 1'b0;
        cyc(1);
        expect_out("R6", 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: PSEN low during reset prevents entry
        enter_reset();
        ale_pin = 1'b0; psen_pin = 1'b0;
        cyc(3);
        rst_pin = 1'b0;
        cyc(1);
        expect_out("R7", 1'b0, 1'b0, 1'b0, 1'b0);
        ale_pin = 1'b1; psen_pin = 1'b1;

        // R10: locked strap captured at reset and held afterwards
        lock_any = 1'b1;
        ea_pin = 1'b1;
        enter_reset();
        cyc(2);
        rst_pin = 1'b0;
        cyc(1);
        expect_out("R10", 1'b0, 1'b0, 1'b1, 1'b1);
        ea_pin = 1'b0;
        cyc(3);
        expect_out("R10", 1'b0, 1'b0, 1'b1, 1'b1);

        // R10: a new reset recaptures the low strap
        enter_reset();
        rst_pin = 1'b0;
        cyc(1);
        ea_pin = 1'b1;
        expect_out("R10", 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1);

        // R11: unlocked strap passes straight through in the same cycle
        lock_any = 1'b0;
        ea_pin = 1'b0;
        expect_out("R11", 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1);
        ea_pin = 1'b1;
        expect_out("R11", 1'b0, 1'b0, 1'b1, 1'b1);
        cyc(2);
        done = 1'b1;
    end

    // Watchdog and final report
    initial begin
        int waited;
        waited = 0;
        while (!done && waited < 20000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule